// File: doc/BRIEF.md
# EEPROM Write-Completion Poller

This block sits on the master side of an I2C bus and runs right after an EEPROM write has been closed with a stop condition. While the part is busy with its internal write, it does not acknowledge its own address. The poller uses that missing acknowledge as a "still busy" signal and keeps probing. It does not treat it as an error. Each probe is a start condition followed by the device's control byte in write direction. As soon as a probe is acknowledged, the poller reports completion so the next read or write can go ahead.

The poller does not toggle SCL or SDA itself. It sends bus operations (start, send byte, stop) to a byte-level I2C engine over a valid/ready command channel. It takes back one result per command over a valid/ready response channel. Only one command is ever outstanding. A command stays on the channel, unchanged, until the engine accepts it. After that the poller asserts `rsp_ready` and waits, for as long as the engine needs, until the result arrives. A retry limit ends a sequence that never gets an acknowledge. A mode input chooses whether a successful probe is closed with a stop or left open for the next command.

Top module: `ackpoll_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `bus_held` and `cmd_valid` are 0, and `attempts` is 0.
- R2: A `go` pulse while idle starts a sequence, with no wait. `cmd_valid` rises in the cycle after `go`, carrying a start (`cmd_op` = 1). The start is followed by a send-byte (`cmd_op` = 2) whose `cmd_byte` is `{dev_addr, 1'b0}`, where bit 0 is the write-direction bit.
- R3: A command held with `cmd_valid` high and `cmd_ready` low keeps `cmd_valid`, `cmd_op` and `cmd_byte` unchanged. No new command is offered until the response to the previous one has been taken.
- R4: When the control byte comes back not acknowledged (`rsp_ack` = 0) and attempts remain, a stop (`cmd_op` = 3) is issued. A new start follows it.
- R5: When the control byte is acknowledged and `keep_open` was 0 at `go`, a stop is issued, then `done` pulses with `timeout` = 0.
- R6: When the control byte is acknowledged and `keep_open` was 1 at `go`, `done` pulses without any stop being issued. `bus_held` then reads 1 until the next accepted `go`.
- R7: `attempts` equals the number of control bytes sent in the latest sequence. It is cleared by an accepted `go` and held after completion.
- R8: After `MAX_TRIES` control bytes in a row that are not acknowledged, a final stop is issued and `done` pulses with `timeout` = 1. No further start is issued. `timeout` reads 1 only when `attempts` equals `MAX_TRIES`.
- R9: `go` pulses while `busy` is high are ignored. The command sequence and the final `attempts` are the same as without them.
- R10: `done` is a single-cycle pulse. In that cycle `busy` is already 0. `dev_addr` and `keep_open` are sampled only when `go` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Begin polling (taken only while idle) |
| keep_open | input | 1 | 1: leave the bus open after the acknowledged probe; 0: close it with a stop |
| dev_addr | input | ADDR_W | 7-bit device address |
| cmd_valid | output | 1 | Command offered to the byte engine |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_op | output | 2 | 1 = start, 2 = send byte, 3 = stop |
| cmd_byte | output | ADDR_W+1 | Byte for a send-byte command |
| rsp_valid | input | 1 | Byte engine result available |
| rsp_ready | output | 1 | Poller accepts the result |
| rsp_ack | input | 1 | 1 = byte acknowledged by the target |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Latest sequence ran out of attempts |
| bus_held | output | 1 | Latest sequence ended with the bus left open |
| attempts | output | CNT_W | Control bytes sent in the latest sequence |

## Verification
Several rules are checked by assertions on every cycle:
- commands stay stable under back-pressure;
- every send-byte carries a write-direction bit;
- a sequence always opens with a start;
- the attempt count never passes its limit, and a timeout always goes with a full count;
- `done` is a lone pulse seen with `busy` low;
- a `go` during a sequence never moves the count.

Other properties need whole scenarios. Only the bench can show them: the exact order of start, send and stop across retries, the choice between a closing stop and an open bus, acknowledgement on the very last allowed attempt, and the timeout path. The bench shows them against an engine model that applies random back-pressure and random response latency.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_START = 2'd1,
    OP_SEND  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_ADDR  = 2'd2,
    ST_STOP  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    WHY_RETRY = 2'd0,
    WHY_OK    = 2'd1,
    WHY_FAIL  = 2'd2
  } stop_why_e;

endpackage

// File: rtl/ackpoll_link.sv
// Command/response handshake toward the byte engine: one command in flight.
module ackpoll_link
  import ackpoll_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  bus_op_e           op_in,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_ack,
  output logic              fin,
  output logic              fin_ack
);

  // phase 0: offering the command, phase 1: waiting for its result
  logic waiting_q;

  assign cmd_valid = active && !waiting_q;
  assign rsp_ready = active && waiting_q;
  assign cmd_op    = op_in;
  assign cmd_byte  = byte_in;
  assign fin       = rsp_ready && rsp_valid;
  assign fin_ack   = rsp_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting_q <= 1'b0;
    end else if (fin) begin
      waiting_q <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      waiting_q <= 1'b1;
    end
  end

  // R3: command held steady under back-pressure
  a_r3_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));

  // R3: after acceptance nothing new is offered until the result arrives
  a_r3_wait_result: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

endmodule

// File: rtl/ackpoll_tries.sv
// Attempt counter with limit detection.
module ackpoll_tries #(
  parameter int MAX_TRIES = 16,
  parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             final_try
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_TRIES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_TRIES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc && cnt_q != FULL) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count     = cnt_q;
  assign final_try = (cnt_q == LAST);

  // R8: the count never passes the limit
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/ackpoll_fsm.sv
// Polling sequence: start, control byte, then stop or retry.
module ackpoll_fsm
  import ackpoll_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              keep_open,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              fin,
  input  logic              fin_ack,
  input  logic              final_try,
  output logic              active,
  output bus_op_e           op,
  output logic [BYTE_W-1:0] byte_o,
  output logic              clr,
  output logic              inc,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              bus_held
);

  seq_state_e        state_q, state_d;
  stop_why_e         why_q, why_d;
  logic              keep_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, timeout_q, held_q;
  logic              finish_ok, finish_open, finish_fail;

  assign active = (state_q != ST_IDLE);
  assign busy   = active;
  assign clr    = (state_q == ST_IDLE) && go;
  assign inc    = (state_q == ST_ADDR) && fin;
  assign byte_o = {addr_q, 1'b0};

  always_comb begin
    unique case (state_q)
      ST_START: op = OP_START;
      ST_ADDR:  op = OP_SEND;
      ST_STOP:  op = OP_STOP;
      default:  op = OP_NONE;
    endcase
  end

  always_comb begin
    state_d     = state_q;
    why_d       = why_q;
    finish_ok   = 1'b0;
    finish_open = 1'b0;
    finish_fail = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) state_d = ST_START;
      end
      ST_START: begin
        if (fin) state_d = ST_ADDR;
      end
      ST_ADDR: begin
        if (fin) begin
          if (fin_ack && keep_q) begin
            state_d     = ST_IDLE;
            finish_open = 1'b1;
          end else begin
            state_d = ST_STOP;
            if (fin_ack)        why_d = WHY_OK;
            else if (final_try) why_d = WHY_FAIL;
            else                why_d = WHY_RETRY;
          end
        end
      end
      ST_STOP: begin
        if (fin) begin
          if (why_q == WHY_RETRY) begin
            state_d = ST_START;
          end else begin
            state_d     = ST_IDLE;
            finish_ok   = (why_q == WHY_OK);
            finish_fail = (why_q == WHY_FAIL);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      why_q     <= WHY_RETRY;
      keep_q    <= 1'b0;
      addr_q    <= '0;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
      held_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      why_q   <= why_d;
      done_q  <= finish_ok || finish_open || finish_fail;
      if (clr) begin
        keep_q    <= keep_open;
        addr_q    <= dev_addr;
        timeout_q <= 1'b0;
        held_q    <= 1'b0;
      end else begin
        if (finish_fail) timeout_q <= 1'b1;
        if (finish_open) held_q    <= 1'b1;
      end
    end
  end

  assign done     = done_q;
  assign timeout  = timeout_q;
  assign bus_held = held_q;

  // R10: single-cycle completion pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: busy is low while done is high
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6: an open bus and a timeout never coexist
  a_r6_held_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_held && timeout));

endmodule

// File: rtl/ackpoll_seq.sv
// Top: write-completion poller driving a byte-level I2C master engine.
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter int  ADDR_W    = 7,
  parameter int  MAX_TRIES = 16,
  localparam int BYTE_W    = ADDR_W + 1,
  localparam int CNT_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              keep_open,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_ack,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              bus_held,
  output logic [CNT_W-1:0]  attempts
);

  logic              active, fin, fin_ack, final_try, clr, inc;
  bus_op_e           op;
  logic [BYTE_W-1:0] byte_w;

  ackpoll_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .keep_open(keep_open),
    .dev_addr(dev_addr), .fin(fin), .fin_ack(fin_ack),
    .final_try(final_try), .active(active), .op(op), .byte_o(byte_w),
    .clr(clr), .inc(inc), .busy(busy), .done(done),
    .timeout(timeout), .bus_held(bus_held)
  );

  ackpoll_tries #(.MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) u_tries (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc),
    .count(attempts), .final_try(final_try)
  );

  ackpoll_link #(.BYTE_W(BYTE_W)) u_link (
    .clk(clk), .rst_n(rst_n), .active(active), .op_in(op),
    .byte_in(byte_w), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .fin(fin), .fin_ack(fin_ack)
  );

  // R2: a sequence opens with a start offered at once
  a_r2_opens_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_valid && cmd_op == 2'(OP_START));

  // R2: every control byte is write-direction
  a_r2_write_dir: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'(OP_SEND) |-> cmd_byte[0] == 1'b0);

  // R8: timeout only with a full attempt count
  a_r8_timeout_full: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> attempts == CNT_W'(MAX_TRIES));

  // R9: go during a sequence does not disturb the count
  a_r9_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && go && !rsp_valid |=> $stable(attempts));

endmodule

// File: tb/sim_ackpoll_seq.sv
`timescale 1ns/1ps
module sim_ackpoll_seq;
  localparam int MAXT = 5;
  localparam int AW   = 7;
  localparam int CW   = $clog2(MAXT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          go = 1'b0, keep_open = 1'b0;
  logic [AW-1:0] dev_addr = '0;
  logic          cmd_valid, cmd_ready = 1'b0;
  logic [1:0]    cmd_op;
  logic [AW:0]   cmd_byte;
  logic          rsp_valid = 1'b0, rsp_ready, rsp_ack = 1'b0;
  logic          busy, done, timeout, bus_held;
  logic [CW-1:0] attempts;

  ackpoll_seq #(.ADDR_W(AW), .MAX_TRIES(MAXT)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .keep_open(keep_open),
    .dev_addr(dev_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .busy(busy), .done(done),
    .timeout(timeout), .bus_held(bus_held), .attempts(attempts)
  );

  int n_chk = 0, n_bad = 0;
  logic [1:0] log_op [64];
  logic [7:0] log_byte [64];
  int log_n = 0, sends_seen = 0, busy_n = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Byte-engine model: random ready, random response latency.
  bit pending = 0, taking = 0, held_prev = 0;
  int dly = 0;
  logic [1:0] pend_op = 2'd0, prev_op = 2'd0;
  logic [7:0] prev_byte = 8'd0;
  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_ready = 0; rsp_valid = 0; pending = 0; taking = 0; held_prev = 0;
    end else begin
      if (held_prev) begin
        chk(cmd_valid && cmd_op == prev_op && cmd_byte == prev_byte,
            "R3 held command", int'(cmd_op), int'(prev_op));
      end
      if (taking) begin
        rsp_valid = 0; taking = 0; pending = 0;
      end
      if (pending && !rsp_valid) begin
        if (dly > 0) dly--;
        else begin
          rsp_valid = 1;
          rsp_ack = (pend_op == 2'd2) ? (sends_seen > busy_n) : 1'b1;
        end
      end
      if (rsp_valid && rsp_ready) taking = 1;
      held_prev = 0;
      if (!pending && cmd_valid) begin
        if ($urandom % 4 != 0) begin
          cmd_ready = 1; pending = 1; dly = $urandom % 3; pend_op = cmd_op;
          if (log_n < 64) begin
            log_op[log_n] = cmd_op; log_byte[log_n] = cmd_byte;
          end
          log_n++;
          if (cmd_op == 2'd2) sends_seen++;
        end else begin
          cmd_ready = 0; held_prev = 1; prev_op = cmd_op; prev_byte = cmd_byte;
        end
      end else begin
        cmd_ready = 0;
      end
    end
  end

  function automatic int exp_tries(input int bn);
    return (bn < MAXT) ? bn + 1 : MAXT;
  endfunction

  task automatic run_case(input int bn, input bit keep, input logic [AW-1:0] addr, input bit poke);
    int tries, k, cyc;
    bit ok;
    log_n = 0; sends_seen = 0; busy_n = bn;
    @(negedge clk); go = 1; keep_open = keep; dev_addr = addr;
    @(negedge clk); go = 0; keep_open = 1'($urandom); dev_addr = AW'($urandom);
    chk(busy == 1'b1, "R2 busy after go", int'(busy), 1);
    chk(cmd_valid && cmd_op == 2'd1, "R2 immediate start", int'(cmd_op), 1);
    chk(attempts == 0, "R7 cleared by go", int'(attempts), 0);
    cyc = 0;
    while (!done && cyc < 3000) begin
      go = (poke && (cyc % 7 == 3)) ? 1'b1 : 1'b0;
      @(negedge clk); cyc++;
    end
    go = 0;
    chk(done == 1'b1, "R10 done reached", int'(done), 1);
    chk(busy == 1'b0, "R10 idle with done", int'(busy), 0);
    ok = (bn < MAXT);
    tries = exp_tries(bn);
    k = 0;
    for (int i = 0; i < tries; i++) begin
      chk(k < log_n && log_op[k] == 2'd1, "R2 start op", int'(log_op[k]), 1); k++;
      chk(k < log_n && log_op[k] == 2'd2 && log_byte[k] == {addr, 1'b0},
          "R2 control byte", int'(log_byte[k]), int'({addr, 1'b0})); k++;
      if (!(i == tries - 1 && ok && keep)) begin
        chk(k < log_n && log_op[k] == 2'd3,
            (i < tries - 1) ? "R4 stop before retry" : (ok ? "R5 closing stop" : "R8 final stop"),
            int'(log_op[k]), 3);
        k++;
      end
    end
    chk(log_n == k, poke ? "R9 sequence length with go pokes" : "R4 sequence length", log_n, k);
    chk(attempts == CW'(tries), "R7 attempts", int'(attempts), tries);
    chk(timeout == !ok, "R8 timeout flag", int'(timeout), int'(!ok));
    chk(bus_held == (ok && keep), "R6 bus held", int'(bus_held), int'(ok && keep));
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(attempts == CW'(tries) && log_n == k, "R7 held after completion", int'(attempts), tries);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: got running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !timeout && !bus_held, "R1 status after reset", int'({busy, done, timeout, bus_held}), 0);
    chk(!cmd_valid && attempts == 0, "R1 idle command side", int'(attempts), 0);
    // directed corners
    run_case(0, 0, 7'h50, 0);      // R5 immediate ack, closing stop
    run_case(0, 1, 7'h51, 0);      // R6 immediate ack, bus left open
    run_case(3, 0, 7'h2a, 0);      // R4 retries
    run_case(MAXT - 1, 1, 7'h7f, 0); // ack on last allowed attempt
    run_case(MAXT, 0, 7'h00, 0);   // R8 exact exhaustion
    run_case(MAXT + 4, 1, 7'h13, 0); // R8 keep_open has no effect on timeout
    run_case(2, 0, 7'h44, 1);      // R9 go pokes while busy
    for (int t = 0; t < 24; t++) begin
      run_case(int'($urandom % (MAXT + 2)), 1'($urandom), AW'($urandom), 1'($urandom));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule